// File: doc/BRIEF.md
# ADC Conversion Sequencer with Sleep Handling

This block is the digital controller wrapped around a 10-bit analog-to-digital converter. Software programs an enable bit, a 2-bit conversion clock source, a justification bit and an interrupt enable. It then raises a go request. The sequencer issues a one-cycle start strobe to the converter and takes the 10-bit code back over a valid/ready handshake. It writes that code into a 16-bit result pair made of a high byte and a low byte. It also raises a sticky interrupt flag.

The block reacts to the core going to sleep. When the internal RC clock source is selected (select code 2'b11), the start strobe is held back by one instruction cycle of `CYC_PER_INSTR` clocks. A conversion already running then survives sleep, and when it finishes it either requests a wake-up or powers the block down. With any other clock source, sleep aborts the conversion and powers the block down. In every case the enable bit stays as software left it. While the block is disabled, the two result bytes serve as plain software registers.

The converter return path follows these back-pressure rules. `conv_ready` is high only while the sequencer waits for a code. A code is taken in the cycle where `conv_valid` and `conv_ready` are both high. `conv_valid` is ignored while `conv_ready` is low. The converter holds `conv_code` steady while `conv_valid` is high. `conv_start` is a plain strobe with no handshake.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, irq_flag, wake_req, powered_down, en_o, conv_start and conv_ready are 0, and both result bytes read 0.
- R2: With a clock select other than 2'b11, a go request accepted at a clock edge sets busy at that edge. conv_start is then high for exactly the following cycle, and conv_ready rises in the cycle after that.
- R3: With clock select 2'b11, conv_start rises exactly CYC_PER_INSTR cycles later than in R2. busy is high throughout the wait.
- R4: On a completed handshake, busy clears, irq_flag sets and the result pair {res_hi,res_lo} loads. With fmt=1 it takes {6'b0,code}; with fmt=0 it takes {code,6'b0}. The fmt value is the one in force at completion.
- R5: conv_ready is high only during the converting phase. A conv_valid pulse while conv_ready is low changes no output.
- R6: While en_o is 0, res_hi_we and res_lo_we write res_wdata into the high and low byte. While en_o is 1, these writes are ignored.
- R7: A go request is ignored while en_o is 0, while powered_down is 1, or while busy is 1. An ignored go request produces no conv_start.
- R8: With clock select 2'b11, a conversion continues across sleep entry. If it completes while asleep with the interrupt enable set, wake_req pulses high for one cycle, at the same time the result appears.
- R9: A conversion that completes while asleep with the interrupt enable clear sets powered_down. wake_req stays low and en_o stays 1.
- R10: Sleep entry with a clock select other than 2'b11 aborts any conversion. busy and conv_ready drop, the result and irq_flag are untouched, and powered_down sets while en_o stays 1. Writing the enable bit to 0 while busy also aborts, without powering down.
- R11: sleep_exit or any configuration write clears powered_down. busy stays 0 until a new go request arrives.
- R12: irq_flag stays set until irq_clr. If a completion and irq_clr occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable bit value to write |
| cfg_clksel | input | 2 | Conversion clock source; 2'b11 is internal RC |
| cfg_fmt | input | 1 | Justification: 1 right, 0 left |
| cfg_ie | input | 1 | Interrupt enable value to write |
| go_set | input | 1 | Go request pulse |
| irq_clr | input | 1 | Clear the interrupt flag |
| sleep_enter | input | 1 | Core enters sleep (pulse) |
| sleep_exit | input | 1 | Core leaves sleep (pulse) |
| res_hi_we | input | 1 | Software write to the high result byte |
| res_lo_we | input | 1 | Software write to the low result byte |
| res_wdata | input | 8 | Software write data |
| conv_start | output | 1 | Start strobe to the converter |
| conv_ready | output | 1 | Sequencer waits for a code |
| conv_valid | input | 1 | Converter presents a code |
| conv_code | input | 10 | Converter output code |
| busy | output | 1 | Go/busy status |
| en_o | output | 1 | Current enable bit |
| irq_flag | output | 1 | Sticky conversion-complete flag |
| wake_req | output | 1 | One-cycle wake-up request |
| powered_down | output | 1 | Block is in its powered-down state |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |

## Verification
The properties assume single-cycle pulses on go_set, sleep_enter and sleep_exit. They also assume that a configuration write never lands in the same cycle as a sleep entry. The bench drives each strobe for one clock from the falling edge and never overlaps configuration writes with sleep events. It raises conv_valid only after it has observed conv_ready, except in the one deliberate out-of-phase pulse that probes R5.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_START = 2'd2,
    ST_CONV  = 2'd3
  } seq_state_t;

  localparam logic [1:0] CLKSEL_RC = 2'b11;
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_en,
  input  logic [1:0] cfg_clksel,
  input  logic       cfg_fmt,
  input  logic       cfg_ie,
  output logic       en_q,
  output logic       fmt_q,
  output logic       ie_q,
  output logic       rc_sel
);
  logic [1:0] clksel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      clksel_q <= 2'b00;
      fmt_q    <= 1'b0;
      ie_q     <= 1'b0;
    end else if (cfg_we) begin
      en_q     <= cfg_en;
      clksel_q <= cfg_clksel;
      fmt_q    <= cfg_fmt;
      ie_q     <= cfg_ie;
    end
  end

  assign rc_sel = (clksel_q == CLKSEL_RC);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CYC_PER_INSTR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic ie_q,
  input  logic rc_sel,
  input  logic cfg_we,
  input  logic cfg_en,
  input  logic go_set,
  input  logic irq_clr,
  input  logic sleep_enter,
  input  logic sleep_exit,
  input  logic conv_valid,
  output logic conv_start,
  output logic conv_ready,
  output logic accept,
  output logic busy,
  output logic irq_flag,
  output logic wake_req,
  output logic powered_down
);
  localparam int CNT_W = (CYC_PER_INSTR > 1) ? $clog2(CYC_PER_INSTR) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYC_PER_INSTR - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             asleep_q;
  logic             abort;
  logic             go_ok;
  logic             pd_set;

  assign busy       = (state_q != ST_IDLE);
  assign abort      = busy && ((sleep_enter && !rc_sel) || (cfg_we && !cfg_en));
  assign conv_start = (state_q == ST_START);
  assign conv_ready = (state_q == ST_CONV) && !abort;
  assign accept     = conv_ready && conv_valid;
  assign go_ok      = go_set && en_q && !powered_down && !busy
                      && !(sleep_enter && !rc_sel);
  assign pd_set     = (sleep_enter && !rc_sel) || (accept && asleep_q && !ie_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (abort) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_ok) begin
          if (rc_sel) begin
            state_q <= ST_WAIT;
            cnt_q   <= CNT_LOAD;
          end else begin
            state_q <= ST_START;
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) state_q <= ST_START;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_START: state_q <= ST_CONV;
        ST_CONV:  if (conv_valid) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q     <= 1'b0;
      powered_down <= 1'b0;
      irq_flag     <= 1'b0;
      wake_req     <= 1'b0;
    end else begin
      if (sleep_enter)     asleep_q <= 1'b1;
      else if (sleep_exit) asleep_q <= 1'b0;

      if (pd_set)                    powered_down <= 1'b1;
      else if (sleep_exit || cfg_we) powered_down <= 1'b0;

      if (accept)       irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;

      wake_req <= accept && asleep_q && ie_q;
    end
  end
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int CODE_W = 10,
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              fmt_right,
  input  logic              en_q,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] res_hi,
  output logic [HALF_W-1:0] res_lo
);
  localparam int PAIR_W = 2 * HALF_W;
  localparam int PAD_W  = PAIR_W - CODE_W;

  logic [PAIR_W-1:0] pair_q;
  logic [PAIR_W-1:0] justified;
  logic [1:0]        sw_we;

  assign justified = fmt_right ? {{PAD_W{1'b0}}, code} : {code, {PAD_W{1'b0}}};
  assign sw_we     = {hi_we, lo_we} & {2{!en_q}};

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pair_q[h*HALF_W +: HALF_W] <= '0;
      else if (load && en_q)
        pair_q[h*HALF_W +: HALF_W] <= justified[h*HALF_W +: HALF_W];
      else if (sw_we[h])
        pair_q[h*HALF_W +: HALF_W] <= wdata;
    end
  end

  assign res_hi = pair_q[PAIR_W-1:HALF_W];
  assign res_lo = pair_q[HALF_W-1:0];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CODE_W        = 10,
  parameter int HALF_W        = 8,
  parameter int CYC_PER_INSTR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_clksel,
  input  logic              cfg_fmt,
  input  logic              cfg_ie,
  input  logic              go_set,
  input  logic              irq_clr,
  input  logic              sleep_enter,
  input  logic              sleep_exit,
  input  logic              res_hi_we,
  input  logic              res_lo_we,
  input  logic [HALF_W-1:0] res_wdata,
  output logic              conv_start,
  output logic              conv_ready,
  input  logic              conv_valid,
  input  logic [CODE_W-1:0] conv_code,
  output logic              busy,
  output logic              en_o,
  output logic              irq_flag,
  output logic              wake_req,
  output logic              powered_down,
  output logic [HALF_W-1:0] res_hi,
  output logic [HALF_W-1:0] res_lo
);
  logic en_q, fmt_q, ie_q, rc_sel, accept;

  adc_seq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_clksel(cfg_clksel), .cfg_fmt(cfg_fmt), .cfg_ie(cfg_ie),
    .en_q(en_q), .fmt_q(fmt_q), .ie_q(ie_q), .rc_sel(rc_sel)
  );

  adc_seq_fsm #(.CYC_PER_INSTR(CYC_PER_INSTR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .ie_q(ie_q), .rc_sel(rc_sel),
    .cfg_we(cfg_we), .cfg_en(cfg_en), .go_set(go_set), .irq_clr(irq_clr),
    .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
    .conv_valid(conv_valid), .conv_start(conv_start),
    .conv_ready(conv_ready), .accept(accept), .busy(busy),
    .irq_flag(irq_flag), .wake_req(wake_req), .powered_down(powered_down)
  );

  adc_seq_result #(.CODE_W(CODE_W), .HALF_W(HALF_W)) u_res (
    .clk(clk), .rst_n(rst_n), .load(accept), .code(conv_code),
    .fmt_right(fmt_q), .en_q(en_q), .hi_we(res_hi_we), .lo_we(res_lo_we),
    .wdata(res_wdata), .res_hi(res_hi), .res_lo(res_lo)
  );

  assign en_o = en_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_start,
  input logic       conv_ready,
  input logic       conv_valid,
  input logic       busy,
  input logic       irq_flag,
  input logic       irq_clr,
  input logic       wake_req,
  input logic       powered_down,
  input logic       en_o,
  input logic       sleep_enter,
  input logic       cfg_we,
  input logic       rc_sel,
  input logic       fmt_q,
  input logic [7:0] res_hi,
  input logic [7:0] res_lo
);
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R3
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready) |=> (!busy && irq_flag)); // R4
  AST_PAD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready && fmt_q) |=> (res_hi[7:2] == 6'd0)); // R4
  AST_PAD_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready && !fmt_q) |=> (res_lo[5:0] == 6'd0)); // R4
  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ready |-> busy); // R5
  AST_GP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && !(conv_valid && conv_ready)) |=> ($stable(res_hi) && $stable(res_lo))); // R6
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req); // R8
  AST_WAKE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> irq_flag); // R8
  AST_SLEEP_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_enter && !cfg_we) |=> $stable(en_o)); // R9
  AST_ABORT_ON_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_enter && !rc_sel && busy && !cfg_we) |=> (!busy && powered_down)); // R10
  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down |-> !conv_start); // R11
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag); // R12
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_ready(conv_ready),
  .conv_valid(conv_valid), .busy(busy), .irq_flag(irq_flag), .irq_clr(irq_clr),
  .wake_req(wake_req), .powered_down(powered_down), .en_o(en_o),
  .sleep_enter(sleep_enter), .cfg_we(cfg_we), .rc_sel(rc_sel), .fmt_q(fmt_q),
  .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CYC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 0, cfg_en = 0, cfg_fmt = 0, cfg_ie = 0;
  logic [1:0] cfg_clksel = 0;
  logic       go_set = 0, irq_clr = 0, sleep_enter = 0, sleep_exit = 0;
  logic       res_hi_we = 0, res_lo_we = 0;
  logic [7:0] res_wdata = 0;
  logic       conv_valid = 0;
  logic [9:0] conv_code = 0;
  logic       conv_start, conv_ready, busy, en_o, irq_flag, wake_req, powered_down;
  logic [7:0] res_hi, res_lo;

  int n_tests = 0;
  int n_fail  = 0;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_clksel(cfg_clksel), .cfg_fmt(cfg_fmt), .cfg_ie(cfg_ie),
    .go_set(go_set), .irq_clr(irq_clr), .sleep_enter(sleep_enter),
    .sleep_exit(sleep_exit), .res_hi_we(res_hi_we), .res_lo_we(res_lo_we),
    .res_wdata(res_wdata), .conv_start(conv_start), .conv_ready(conv_ready),
    .conv_valid(conv_valid), .conv_code(conv_code), .busy(busy), .en_o(en_o),
    .irq_flag(irq_flag), .wake_req(wake_req), .powered_down(powered_down),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_cfg(input logic en, input logic [1:0] cs, input logic fmt, input logic ie);
    cfg_we = 1; cfg_en = en; cfg_clksel = cs; cfg_fmt = fmt; cfg_ie = ie;
    tick();
    cfg_we = 0;
  endtask

  task automatic pulse_go();
    go_set = 1; tick(); go_set = 0;
  endtask

  // Go, then wait for conv_start; returns the number of cycles waited.
  task automatic go_and_wait(output int n);
    pulse_go();
    n = 0;
    while (!conv_start && n < 50) begin tick(); n++; end
  endtask

  task automatic finish_conv(input logic [9:0] code);
    conv_code = code; conv_valid = 1; tick(); conv_valid = 0;
  endtask

  function automatic logic [15:0] just(input logic fmt, input logic [9:0] c);
    return fmt ? {6'd0, c} : {c, 6'd0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] held;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", {busy, irq_flag, wake_req, powered_down, en_o, conv_start, conv_ready}, 0);
    chk("R1 result", {res_hi, res_lo}, 0);
    rst_n = 1;
    tick();

    // R6 software access while disabled
    res_wdata = 8'hA5; res_hi_we = 1; tick(); res_hi_we = 0;
    res_wdata = 8'h3C; res_lo_we = 1; tick(); res_lo_we = 0;
    chk("R6 gp write", {res_hi, res_lo}, 16'hA53C);

    // R7 go ignored while disabled
    pulse_go();
    chk("R7 disabled go", {busy, conv_start}, 0);

    set_cfg(1, 2'b00, 1, 0);
    // R6 writes ignored while enabled
    res_wdata = 8'hFF; res_hi_we = 1; res_lo_we = 1; tick(); res_hi_we = 0; res_lo_we = 0;
    chk("R6 locked", {res_hi, res_lo}, 16'hA53C);

    // R5 valid while not ready
    conv_code = 10'h155; conv_valid = 1; tick(); conv_valid = 0;
    chk("R5 stray valid", {busy, irq_flag, res_hi, res_lo}, {2'b00, 16'hA53C});

    // R2 R3 R4 sweep over clock source, format and codes
    for (int cs = 0; cs < 4; cs++) begin
      for (int f = 0; f < 2; f++) begin
        for (int k = 0; k < 10; k++) begin
          logic [9:0] code;
          code = (k == 9) ? 10'h3FF : 10'((k * 113) & 10'h3FF);
          set_cfg(1, 2'(cs), f[0], 0);
          irq_clr = 1; tick(); irq_clr = 0;
          go_and_wait(n);
          chk(cs == 3 ? "R3 rc delay" : "R2 start timing", n, cs == 3 ? CYC : 0);
          chk("R2 busy", busy, 1);
          tick();
          chk("R2 ready after start", {conv_start, conv_ready}, 2'b01);
          finish_conv(code);
          chk("R4 result", {res_hi, res_lo}, just(f[0], code));
          chk("R4 flags", {busy, irq_flag, conv_ready}, 3'b010);
        end
      end
    end

    // R7 go while busy does not restart
    set_cfg(1, 2'b01, 1, 0);
    go_and_wait(n); tick();
    pulse_go();
    chk("R7 busy go", {conv_start, conv_ready}, 2'b01);
    // R12 completion and clear together keeps flag
    irq_clr = 1; finish_conv(10'h2AA); irq_clr = 0;
    chk("R12 set wins", irq_flag, 1);
    tick();
    chk("R12 sticky", irq_flag, 1);
    irq_clr = 1; tick(); irq_clr = 0;
    chk("R12 cleared", irq_flag, 0);

    // R8 RC conversion across sleep, interrupt enabled
    set_cfg(1, 2'b11, 0, 1);
    pulse_go();
    sleep_enter = 1; tick(); sleep_enter = 0;
    n = 1;
    while (!conv_start && n < 50) begin tick(); n++; end
    chk("R8 start during sleep", n, CYC);
    tick();
    finish_conv(10'h1C3);
    chk("R8 wake", {wake_req, powered_down, busy}, 3'b100);
    chk("R8 result", {res_hi, res_lo}, just(0, 10'h1C3));
    tick();
    chk("R8 wake pulse", wake_req, 0);
    sleep_exit = 1; tick(); sleep_exit = 0;

    // R9 RC conversion across sleep, interrupt disabled
    set_cfg(1, 2'b11, 1, 0);
    go_and_wait(n);
    sleep_enter = 1; tick(); sleep_enter = 0;
    chk("R8 rc survives sleep", {busy, conv_ready}, 2'b11);
    finish_conv(10'h0F0);
    chk("R9 power down", {wake_req, powered_down, en_o}, 3'b011);
    // R11 go ignored while powered down
    pulse_go();
    chk("R11 off go", {busy, conv_start}, 0);
    sleep_exit = 1; tick(); sleep_exit = 0;
    chk("R11 exit", {powered_down, busy}, 0);
    pulse_go();
    chk("R11 new go", busy, 1);
    go_and_wait(n); tick(); finish_conv(10'h001);
    irq_clr = 1; tick(); irq_clr = 0;

    // R10 non-RC sleep aborts
    set_cfg(1, 2'b10, 1, 0);
    held = {res_hi, res_lo};
    go_and_wait(n); tick();
    sleep_enter = 1; tick(); sleep_enter = 0;
    chk("R10 abort", {busy, conv_ready, irq_flag, powered_down, en_o}, 5'b00011);
    chk("R10 result kept", {res_hi, res_lo}, held);
    conv_code = 10'h3FF; conv_valid = 1; tick(); conv_valid = 0;
    chk("R10 late valid", {res_hi, res_lo, irq_flag}, {held, 1'b0});
    sleep_exit = 1; tick(); sleep_exit = 0;
    // R11 config write clears power-down
    sleep_enter = 1; tick(); sleep_enter = 0;
    chk("R10 idle sleep off", powered_down, 1);
    set_cfg(1, 2'b10, 1, 0);
    chk("R11 cfg clears", {powered_down, busy}, 0);
    sleep_exit = 1; tick(); sleep_exit = 0;

    // R10 disable while busy aborts without power-down
    go_and_wait(n);
    set_cfg(0, 2'b10, 1, 0);
    chk("R10 disable abort", {busy, conv_ready, powered_down, en_o}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule